// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block sits beside the conversion engine of a sampling converter and delivers each 16-bit result to a host over a serial link. The converter drives that link itself. The block makes the serial clock from the system clock through a divider. It raises a framing strobe for as long as the bits on the data line are valid, and it shifts each word out most significant bit first. The data line changes on the clock edge that returns the serial clock to its idle level, so the host samples it on the edge that leaves idle.

Two schedules are offered, chosen at the moment a conversion is accepted:

- **After-conversion (mode 0):** the result just produced is sent once the conversion completes. The busy indication is held until the last bit has gone out.
- **During-conversion (mode 1):** the previously captured result is sent while the new conversion runs. Busy covers only the conversion itself.

After reset no earlier result exists. For that first frame, a parameter chooses between sending zeros and sending nothing. The polarity of the serial clock and the polarity of the framing strobe can each be inverted. When the clock-source select is high, the block does not act as master: it sends no frames, but conversions still run and are captured.

Top module: `conv_serial_master`

## Requirements
- R1: A conversion start is accepted only when `convBusy` is low and no frame is in progress. `convBusy` rises in the cycle after an accepted start. Any other start pulse has no effect.
- R2: In mode 1, or when `extClkSel` is 1, `convBusy` falls in the cycle after the conversion-complete pulse.
- R3: In mode 0 with `extClkSel` at 0, `convBusy` stays high through the frame. It falls on the same clock edge on which the frame ends, which is 32×HALF_DIV cycles after the conversion-complete pulse.
- R4: A frame carries exactly 16 bits, most significant first, over 16 serial-clock pulses. Each pulse is high for HALF_DIV system cycles and low for HALF_DIV system cycles.
- R5: Within a frame, `serData` changes only on an edge that returns `serClk` to its idle level.
- R6: In mode 0, the frame carries the data presented with the conversion-complete pulse of that same conversion. It starts in the cycle after that pulse.
- R7: In mode 1, the frame carries the most recently captured result. It starts in the cycle after the start is accepted.
- R8: The first mode-1 frame after reset carries all zeros with the framing strobe active when ZERO_FIRST=1. When ZERO_FIRST=0, no frame is sent.
- R9: The framing strobe is active for the whole frame. Active is high when `syncInv`=0 and low when `syncInv`=1. When `clkInv`=1, `serClk` idles high.
- R10: Outside a frame, including during reset, `serClk` equals `clkInv`, `frameSync` equals `syncInv`, and `serData` is 0.
- R11: When `extClkSel` is 1 at launch time, no frame is sent and `serClk` stays idle.
- R12: A conversion-complete pulse while no conversion is in progress is ignored. The stored result is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| convStart | input | 1 | Request to begin a conversion |
| convDone | input | 1 | One-cycle pulse from the conversion engine, result valid |
| convData | input | DATA_W | Parallel result, valid with `convDone` |
| readDuring | input | 1 | Schedule select: 0 after conversion, 1 during next conversion |
| clkInv | input | 1 | Invert serial clock polarity |
| syncInv | input | 1 | Invert framing strobe polarity |
| extClkSel | input | 1 | 1 = external clock source, master output disabled |
| convBusy | output | 1 | Conversion (and mode-0 readout) in progress |
| frameSync | output | 1 | Framing strobe, data on `serData` valid |
| serClk | output | 1 | Serial clock generated by the block |
| serData | output | 1 | Serial data, MSB first |

## Verification
On every cycle, the assertions check four things:

- idle levels whenever no frame is in progress;
- that data moves only on the edge returning the serial clock to idle;
- that each finished frame contained exactly 16 clock pulses;
- that `convBusy` rises only after an accepted start and falls only after a completion pulse or at the end of a frame.

Some behaviour only the bench scenarios can show. These are which word a frame carries in each schedule, the zero or suppressed first frame after reset, and the exact cycle on which busy drops in each mode. They also include the fact that stray start and completion pulses leave both timing and stored data untouched.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;

  // Conversion-side phase of the controller
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_TAIL = 2'd2
  } conv_phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // store the parallel result
    logic loadNew;   // start a frame with the incoming result
    logic loadPrev;  // start a frame with the stored result
    logic loadZero;  // start a frame of zeros
  } strobe_t;

endpackage

// File: rtl/conv_serial_ctrl.sv
module conv_serial_ctrl
  import conv_serial_pkg::*;
#(
  parameter bit ZERO_FIRST = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    convStart,
  input  logic    convDone,
  input  logic    readDuring,
  input  logic    extClkSel,
  input  logic    frmActive,
  input  logic    frmDone,
  output strobe_t strb,
  output logic    convBusy
);

  conv_phase_e phase;
  logic        modeLat;
  logic        prevRdy;
  logic        startOk;
  logic        doneOk;
  logic        launchNew;
  logic        launchOld;

  always_comb begin
    startOk   = convStart && (phase == PH_IDLE) && !frmActive;
    doneOk    = convDone && (phase == PH_CONV);
    launchNew = doneOk && !modeLat && !extClkSel;
    launchOld = startOk && readDuring && !extClkSel;

    strb.capture  = doneOk;
    strb.loadNew  = launchNew;
    strb.loadPrev = launchOld && prevRdy;
    strb.loadZero = launchOld && !prevRdy && ZERO_FIRST;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      modeLat <= 1'b0;
      prevRdy <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (startOk) begin
            phase   <= PH_CONV;
            modeLat <= readDuring;
          end
        end
        PH_CONV: begin
          if (doneOk) begin
            phase <= launchNew ? PH_TAIL : PH_IDLE;
          end
        end
        PH_TAIL: begin
          if (frmDone) begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
      if (doneOk) begin
        prevRdy <= 1'b1;
      end
    end
  end

  assign convBusy = (phase != PH_IDLE);

endmodule

// File: rtl/conv_serial_dpath.sv
module conv_serial_dpath
  import conv_serial_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] convData,
  input  logic              clkInv,
  input  logic              syncInv,
  output logic              frmActive,
  output logic              frmDone,
  output logic              serClk,
  output logic              frameSync,
  output logic              serData
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DATA_W-1:0] resReg;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] loadVal;
  logic [CNT_W-1:0]  bitCnt;
  logic              clkHigh;
  logic              active;
  logic              load;
  logic              halfTick;
  logic              lastBit;

  assign load    = strb.loadNew | strb.loadPrev | strb.loadZero;
  assign lastBit = (bitCnt == CNT_W'(DATA_W - 1));

  always_comb begin
    if (strb.loadNew) begin
      loadVal = convData;
    end else if (strb.loadPrev) begin
      loadVal = resReg;
    end else begin
      loadVal = '0;
    end
  end

  // Parallel result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0;
    end else if (strb.capture) begin
      resReg <= convData;
    end
  end

  // Half-period divider
  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign halfTick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (load || !active) begin
          divCnt <= '0;
        end else if (divCnt == DIV_W'(HALF_DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign halfTick = (divCnt == DIV_W'(HALF_DIV - 1));
    end
  endgenerate

  // Shifter and clock phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      clkHigh <= 1'b0;
      bitCnt  <= '0;
      shReg   <= '0;
    end else if (load) begin
      active  <= 1'b1;
      clkHigh <= 1'b0;
      bitCnt  <= '0;
      shReg   <= loadVal;
    end else if (active && halfTick) begin
      if (!clkHigh) begin
        clkHigh <= 1'b1;
      end else begin
        clkHigh <= 1'b0;
        if (lastBit) begin
          active <= 1'b0;
          shReg  <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
          shReg  <= {shReg[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign frmActive = active;
  assign frmDone   = active && halfTick && clkHigh && lastBit;
  assign serClk    = (active & clkHigh) ^ clkInv;
  assign frameSync = active ^ syncInv;
  assign serData   = active & shReg[DATA_W-1];

endmodule

// File: rtl/conv_serial_master.sv
module conv_serial_master
  import conv_serial_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 2,
  parameter bit ZERO_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic              readDuring,
  input  logic              clkInv,
  input  logic              syncInv,
  input  logic              extClkSel,
  output logic              convBusy,
  output logic              frameSync,
  output logic              serClk,
  output logic              serData
);

  strobe_t strb;
  logic    frmActive;
  logic    frmDone;

  conv_serial_ctrl #(
    .ZERO_FIRST(ZERO_FIRST)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .convStart (convStart),
    .convDone  (convDone),
    .readDuring(readDuring),
    .extClkSel (extClkSel),
    .frmActive (frmActive),
    .frmDone   (frmDone),
    .strb      (strb),
    .convBusy  (convBusy)
  );

  conv_serial_dpath #(
    .DATA_W  (DATA_W),
    .HALF_DIV(HALF_DIV)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .convData (convData),
    .clkInv   (clkInv),
    .syncInv  (syncInv),
    .frmActive(frmActive),
    .frmDone  (frmDone),
    .serClk   (serClk),
    .frameSync(frameSync),
    .serData  (serData)
  );

endmodule

// File: rtl/conv_serial_chk.sv
module conv_serial_chk #(
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic convDone,
  input logic convBusy,
  input logic serClk,
  input logic frameSync,
  input logic serData,
  input logic clkInv,
  input logic syncInv,
  input logic frmActive
);

  localparam int CW = $clog2(DATA_W + 1) + 1;

  logic [CW-1:0] riseCnt;
  logic          prevRaw;
  logic          rawClk;

  assign rawClk = serClk ^ clkInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0;
      prevRaw <= 1'b0;
    end else begin
      prevRaw <= rawClk;
      if (!frmActive) begin
        riseCnt <= '0;
      end else if (rawClk && !prevRaw) begin
        riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  // R1: busy only rises after a start seen while no frame ran
  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convBusy) |-> ($past(convStart) && !$past(frmActive)));

  // R2 / R3: busy drops only after a completion pulse or at frame end
  assert_busy_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convBusy) |-> ($past(convDone) || $fell(frmActive)));

  // R4: every finished frame had the full pulse count
  assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frmActive) |-> (riseCnt == CW'(DATA_W)));

  // R5: data moves only with the return of the clock to idle
  assert_data_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frmActive && $past(frmActive) && $stable(clkInv) && (serData != $past(serData)))
      |-> (serClk == clkInv));

  // R10: idle levels outside a frame
  assert_idle_levels_R10: assert property (@(posedge clk) disable iff (!rstN)
    !frmActive |-> ((serClk == clkInv) && (frameSync == syncInv) && !serData));

endmodule

bind conv_serial_master conv_serial_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .convStart(convStart),
  .convDone (convDone),
  .convBusy (convBusy),
  .serClk   (serClk),
  .frameSync(frameSync),
  .serData  (serData),
  .clkInv   (clkInv),
  .syncInv  (syncInv),
  .frmActive(frmActive)
);

// File: tb/conv_serial_master_tb_top.sv
`timescale 1ns/1ps
module conv_serial_master_tb_top;

  localparam int DATA_W   = 16;
  localparam int HALF_DIV = 2;
  localparam int CONV_CYC = 80;
  localparam int LEN      = 200;
  localparam int FRAME_CYC = 2 * HALF_DIV * DATA_W;
  localparam int WDOG     = 150000;

  // {readDuring, extClkSel, clkInv, syncInv, strayStart, data}
  localparam logic [20:0] VECS [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h8001},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hBEEF},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h7E81},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h8000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStart = 1'b0;
  logic convDone = 1'b0;
  logic [DATA_W-1:0] convData = '0;
  logic readDuring = 1'b0;
  logic clkInv = 1'b0;
  logic syncInv = 1'b0;
  logic extClkSel = 1'b0;
  logic convBusy, frameSync, serClk, serData;
  logic convBusy2, frameSync2, serClk2, serData2;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit prevValid = 1'b0;
  logic [DATA_W-1:0] prevData = '0;

  always #4 clk = ~clk;

  conv_serial_master #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .ZERO_FIRST(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convData(convData), .readDuring(readDuring), .clkInv(clkInv),
    .syncInv(syncInv), .extClkSel(extClkSel), .convBusy(convBusy),
    .frameSync(frameSync), .serClk(serClk), .serData(serData)
  );

  conv_serial_master #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .ZERO_FIRST(1'b0)) dut_sup_i (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
    .convData(convData), .readDuring(readDuring), .clkInv(clkInv),
    .syncInv(syncInv), .extClkSel(extClkSel), .convBusy(convBusy2),
    .frameSync(frameSync2), .serClk(serClk2), .serData(serData2)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(serClk == clkInv, req, "idle serClk", int'(serClk), int'(clkInv));
    check(frameSync == syncInv, req, "idle frameSync", int'(frameSync), int'(syncInv));
    check(serData == 1'b0, req, "idle serData", int'(serData), 0);
  endtask

  task automatic runVec(input logic [20:0] v, input int idx, input string dataTag);
    bit mode, ext, sI, yI, stray;
    logic [DATA_W-1:0] data, expData, shiftIn;
    int bits, frames, frames2, busyFall, firstSync, midAt, expFall, expFirst;
    bit prevRaw, prevSa, prevSa2, raw, sa, sa2, busyAtStart;
    {mode, ext, sI, yI, stray, data} = v;
    shiftIn = '0; bits = 0; frames = 0; frames2 = 0; busyFall = -1; firstSync = -1;
    prevRaw = 1'b0; prevSa = 1'b0; prevSa2 = 1'b0; busyAtStart = 1'b0;
    midAt = mode ? 40 : 100;
    @(negedge clk);
    readDuring = mode; extClkSel = ext; clkInv = sI; syncInv = yI;
    convStart = 1'b1;
    for (int cnt = 1; cnt <= LEN; cnt++) begin
      @(negedge clk);
      convStart = stray && (cnt == midAt);
      convDone  = (cnt == CONV_CYC);
      convData  = (cnt == CONV_CYC) ? data : 16'hDEAD;
      if (cnt == 1) busyAtStart = convBusy;
      raw = serClk ^ sI;
      sa  = frameSync ^ yI;
      sa2 = frameSync2 ^ yI;
      if (sa && !prevSa) begin
        frames++;
        if (firstSync < 0) firstSync = cnt;
      end
      if (sa2 && !prevSa2) frames2++;
      if (sa && raw && !prevRaw) begin
        shiftIn = {shiftIn[DATA_W-2:0], serData};
        bits++;
      end
      if (!convBusy && busyFall < 0 && cnt > 1) busyFall = cnt;
      prevRaw = raw; prevSa = sa; prevSa2 = sa2;
    end

    expData  = mode ? (prevValid ? prevData : '0) : data;
    expFall  = (!mode && !ext) ? (CONV_CYC + 1 + FRAME_CYC) : (CONV_CYC + 1);
    expFirst = mode ? 1 : (CONV_CYC + 1);

    check(busyAtStart, "R1", $sformatf("v%0d busy after start", idx), int'(busyAtStart), 1);
    check(busyFall == expFall, (!mode && !ext) ? "R3" : "R2",
          $sformatf("v%0d busy fall cycle", idx), busyFall, expFall);
    check(convBusy == 1'b0, "R1", $sformatf("v%0d busy low at end (stray start ignored)", idx),
          int'(convBusy), 0);
    if (ext) begin
      check(frames == 0, "R11", $sformatf("v%0d frames with external clock", idx), frames, 0);
      check(bits == 0, "R11", $sformatf("v%0d clock pulses with external clock", idx), bits, 0);
    end else begin
      check(frames == 1, "R9", $sformatf("v%0d frame count", idx), frames, 1);
      check(bits == DATA_W, "R4", $sformatf("v%0d bits in frame", idx), bits, DATA_W);
      check(shiftIn == expData, dataTag, $sformatf("v%0d frame word", idx),
            int'(shiftIn), int'(expData));
      check(firstSync == expFirst, mode ? "R7" : "R6",
            $sformatf("v%0d frame start cycle", idx), firstSync, expFirst);
    end
    if (idx == 0) begin
      // R8: suppressed first frame on the ZERO_FIRST=0 instance
      check(frames2 == 0, "R8", "v0 suppressed first frame", frames2, 0);
    end
    if (idx == 1) begin
      check(frames2 == 1, "R8", "v1 frame after suppressed one", frames2, 1);
    end
    checkIdle("R10");
    prevValid = 1'b1;
    prevData  = data;
  endtask

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    check(convBusy == 1'b0, "R10", "busy in reset", int'(convBusy), 0);
    checkIdle("R10");
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: first vector also covers the zero first frame (R8)
    for (int i = 0; i < 8; i++) begin
      runVec(VECS[i], i, (i == 0) ? "R8" : (VECS[i][20] ? "R7" : "R6"));
    end

    // R12: stray completion pulse while idle must not replace the stored word
    @(negedge clk);
    convDone = 1'b1; convData = 16'h1111;
    @(negedge clk);
    convDone = 1'b0; convData = '0;
    @(negedge clk);
    check(convBusy == 1'b0, "R12", "busy after stray completion", int'(convBusy), 0);
    checkIdle("R12");
    runVec({1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2222}, 8, "R12");

    // Reset during a frame: idle levels at once, stored word forgotten
    @(negedge clk);
    readDuring = 1'b1; clkInv = 1'b1; syncInv = 1'b0; extClkSel = 1'b0;
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    repeat (10) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(convBusy == 1'b0, "R10", "busy after reset mid-frame", int'(convBusy), 0);
    checkIdle("R10");
    rstN = 1'b1;
    prevValid = 1'b0;
    repeat (2) @(negedge clk);
    runVec({1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h3C3C}, 9, "R8");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL all watchdog: actual %0d cycles expected completion", WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule